// File: doc/BRIEF.md
# Chip-Select Kicked Watchdog Timer

This block is a supervisory watchdog that counts ticks of a slow time base and requests a system reset when software stops showing signs of life. Software keeps it quiet through ordinary bus traffic. Every change of level on the chip-select line, rising or falling, restarts the count from zero. No dedicated kick pin is needed.

The count is held at zero whenever the system is not in a state where a watchdog timeout means anything. This covers three cases: the supply is below its trip level, the power-up reset period is still running, or an externally applied reset is active. Counting resumes only once every one of these conditions has cleared, so the hold lasts for whichever of the power-up period and the external reset ends later. When the count expires, the block issues a one-clock timeout request to the reset generator. That generator drives both reset outputs and signals its own reset period back through the power-up-busy input, which keeps the watchdog held until the reset it caused has finished.

The block runs on the system clock. The slow time base arrives as a one-clock tick enable, nominally 5 kHz, and the default expiry of 8000 ticks gives a 1.6 s period. Chip-select is asynchronous and is synchronized inside the block.

Top module: `wdt_cs_kick`

## Requirements
- R1: While `rst_ni` is low, `timeout_o` is low and the internal count is zero.
- R2: With no clear condition, `timeout_o` goes high for exactly one clock, in the clock after the edge that samples the LIMIT-th tick counted since the last clear (LIMIT defaults to 8000).
- R3: After a timeout the count restarts from zero, so the next timeout needs another LIMIT ticks. If the reset that the timeout caused shows up on `por_busy_i`, the count stays held until that input falls.
- R4: A rising edge on `cs_i` clears the count. The clear takes effect at the third rising clock edge after the change, following two synchronizer stages and one edge-detect compare.
- R5: A falling edge on `cs_i` clears the count in the same way as a rising edge.
- R6: One edge clears the count exactly once. Holding `cs_i` at a steady level afterwards, high or low, does not keep the count cleared.
- R7: While `supply_ok_i` is low, the count is held at zero and no timeout is issued, however many ticks arrive.
- R8: While `por_busy_i` is high, the count is held at zero and no timeout is issued.
- R9: While `ext_rst_i` is high, the count is held at zero. Counting restarts from zero only when both `por_busy_i` and `ext_rst_i` are low, whichever of the two falls later.
- R10: Clock cycles without a tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock enable from the slow time base |
| cs_i | input | 1 | Bus chip-select, asynchronous; any edge kicks the watchdog |
| supply_ok_i | input | 1 | High when the supply is above the trip level |
| por_busy_i | input | 1 | High while the power-up (or watchdog-caused) reset period runs |
| ext_rst_i | input | 1 | High while an externally applied reset is active |
| timeout_o | output | 1 | One-clock timeout request to the reset generator |

## Verification
A timeout is due in the clock after the edge that samples the expiring tick. The bench therefore raises each tick for one full clock between falling edges and samples `timeout_o` at the next falling edge. There it compares the tick number against the next number queued by the driver. A chip-select change needs three clock edges to clear the count, so the driver leaves five tick-free clocks after each change before it resumes ticking. Hold inputs act at the very next edge. Any pulse the queue does not predict is reported against the requirement under test, and each phase ends by confirming that no expected pulse is still pending.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // True when the count sits on the last value before expiry.
  function automatic logic wdt_at_end(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // The count is held cleared while any of the system conditions block it.
  function automatic logic wdt_hold(input logic supply_ok, input logic por_busy,
                                    input logic ext_rst);
    return (!supply_ok) || por_busy || ext_rst;
  endfunction

  // Width needed to hold counts 0 .. limit-1.
  function automatic int unsigned wdt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  // Any level change, either direction, yields a single-cycle pulse.
  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_hold_gate.sv
module wdt_hold_gate (
  input  logic supply_ok_i,
  input  logic por_busy_i,
  input  logic ext_rst_i,
  output logic hold_o
);
  import wdt_pkg::*;
  always_comb hold_o = wdt_hold(supply_ok_i, por_busy_i, ext_rst_i);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned LIMIT = 8000,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             at_end_w;

  always_comb at_end_w = wdt_at_end(32'(cnt_q), LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (at_end_w) begin
          cnt_q <= '0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/wdt_cs_kick.sv
module wdt_cs_kick #(
  parameter int unsigned LIMIT       = 8000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cs_i,
  input  logic supply_ok_i,
  input  logic por_busy_i,
  input  logic ext_rst_i,
  output logic timeout_o
);
  import wdt_pkg::*;
  localparam int unsigned CNT_W = wdt_width(LIMIT);

  logic             kick_w;
  logic             hold_w;
  logic             clear_w;
  logic [CNT_W-1:0] count_w;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cs_i),
    .edge_o (kick_w)
  );

  wdt_hold_gate u_hold (
    .supply_ok_i(supply_ok_i),
    .por_busy_i (por_busy_i),
    .ext_rst_i  (ext_rst_i),
    .hold_o     (hold_w)
  );

  assign clear_w = hold_w | kick_w;

  wdt_count #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (clear_w),
    .count_o (count_w),
    .expire_o(timeout_o)
  );
endmodule

// File: rtl/wdt_cs_kick_chk.sv
module wdt_cs_kick_chk #(
  parameter int unsigned LIMIT = 8000,
  parameter int unsigned CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             supply_ok_i,
  input logic             por_busy_i,
  input logic             ext_rst_i,
  input logic             timeout_o,
  input logic             kick_w,
  input logic [CNT_W-1:0] count_w
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!timeout_o && count_w == '0)
        else $error("timeout or count active in reset");
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_w < CNT_W'(LIMIT));

  p_restart_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> count_w == '0);

  p_kick_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_w |=> count_w == '0);

  p_supply_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!timeout_o && count_w == '0));

  p_por_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_busy_i |=> (!timeout_o && count_w == '0));

  p_ext_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (!timeout_o && count_w == '0));

  p_no_tick_still_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !kick_w && supply_ok_i && !por_busy_i && !ext_rst_i) |=> $stable(count_w));
endmodule

bind wdt_cs_kick wdt_cs_kick_chk #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .supply_ok_i(supply_ok_i),
  .por_busy_i (por_busy_i),
  .ext_rst_i  (ext_rst_i),
  .timeout_o  (timeout_o),
  .kick_w     (kick_w),
  .count_w    (count_w)
);

// File: tb/sim_wdt_cs_kick.sv
`timescale 1ns/1ps
module sim_wdt_cs_kick;
  localparam int unsigned L = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cs = 1'b0, sup = 1'b0, por = 1'b0, ext = 1'b0;
  logic tmo;

  int checks = 0, errors = 0;
  int tick_no = 0;
  int exp_q[$];
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_cs_kick #(.LIMIT(L), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_i(cs),
    .supply_ok_i(sup), .por_busy_i(por), .ext_rst_i(ext), .timeout_o(tmo)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: each timeout pulse is compared with the next predicted tick number.
  always @(negedge clk) begin
    if (rst_n && tmo && !done) begin
      if (exp_q.size() == 0) check(1'b0, cur_req, tick_no, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(tick_no == e, cur_req, tick_no, e);
      end
    end
  end

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; tick_no++;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_after(input int n);
    exp_q.push_back(tick_no + n);
  endtask

  task automatic phase_end(input string req);
    idle(3);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic flip_cs();
    @(negedge clk); cs = ~cs;
    idle(5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(tmo == 1'b0, "R1", tmo, 0);
    @(negedge clk); rst_n = 1'b1; sup = 1'b1;

    cur_req = "R2"; expect_after(L); run_ticks(L); phase_end("R2");
    cur_req = "R3"; expect_after(L); run_ticks(L); phase_end("R3");

    cur_req = "R4"; run_ticks(L-3); flip_cs(); expect_after(L); run_ticks(L); phase_end("R4");
    cur_req = "R5"; run_ticks(L-3); flip_cs(); expect_after(L); run_ticks(L); phase_end("R5");

    // R6: single edge, then cs held high steadily for a full period
    cur_req = "R6"; flip_cs(); expect_after(L); run_ticks(L); phase_end("R6");
    flip_cs(); idle(2);

    cur_req = "R7"; run_ticks(5); sup = 1'b0; run_ticks(2*L);
    @(negedge clk); sup = 1'b1; expect_after(L); run_ticks(L); phase_end("R7");

    cur_req = "R8"; run_ticks(5); por = 1'b1; run_ticks(2*L);
    @(negedge clk); por = 1'b0; expect_after(L); run_ticks(L); phase_end("R8");

    // R9: external reset outlasts power-up period
    cur_req = "R9"; run_ticks(5); por = 1'b1; ext = 1'b1; run_ticks(L);
    @(negedge clk); por = 1'b0; run_ticks(L+2);
    @(negedge clk); ext = 1'b0; expect_after(L); run_ticks(L); phase_end("R9");
    // R9: power-up period outlasts external reset
    run_ticks(5); por = 1'b1; ext = 1'b1; run_ticks(L);
    @(negedge clk); ext = 1'b0; run_ticks(L+2);
    @(negedge clk); por = 1'b0; expect_after(L); run_ticks(L); phase_end("R9");

    // R3: reset caused by a timeout holds the count until it ends
    cur_req = "R3"; expect_after(L); run_ticks(L);
    por = 1'b1; run_ticks(2*L); @(negedge clk); por = 1'b0;
    expect_after(L); run_ticks(L); phase_end("R3");

    // R10: clocks without ticks leave the count unchanged
    cur_req = "R10"; run_ticks(L-1); idle(10*L); expect_after(1); run_ticks(1); phase_end("R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule